// File: doc/BRIEF.md
# GPIO Port Controller with Interrupt Detection

This block controls one port of up to 32 general-purpose pins behind a simple word-wide register bus. Writes take effect on the clock edge where the write strobe is high. Reads return data from the current address without delay. Software can drive the output data register in three ways: a direct write, a write-one-to-set alias, or a write-one-to-clear alias. A direction register selects which pins drive, and the pad drive is exposed as separate data and output-enable vectors. Input pins pass through a two-flop synchronizer before software reads them or the detection logic sees them.

Each pin has its own interrupt trigger, chosen by three bit registers: type (level or edge), polarity, and both-edge. A trigger only records an event when the pin's enable bit is set. Recorded events stay in a status register until software writes ones to the clear offset. A separate mask register removes status bits from the single combined interrupt line but leaves the status itself untouched. The pull-control and debounce registers only store the value written to them.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads zero, `pin_o`, `pin_oe_o` and `irq_o` are low, and all pins are inputs.
- R2: A write to offset 0x00 loads the output data register, which drives `pin_o`. A write to offset 0x08 loads the direction register, which drives `pin_oe_o` (1 = output). Both registers read back at their own offsets.
- R3: A write to offset 0x10 sets every output bit where the written word holds a one and leaves the other output bits unchanged.
- R4: A write to offset 0x14 clears every output bit where the written word holds a one and leaves the other output bits unchanged.
- R5: A read of offset 0x04 returns the pin levels through a two-flop synchronizer. A pin change driven before a clock edge becomes readable after the second clock edge.
- R6: When a pin's bit at offset 0x34 is 1, the pin uses level detection. Its bit at offset 0x3C selects the active level: 0 = high, 1 = low. While the synchronized level is active, the status bit sets on every cycle, so it re-asserts right after a clear.
- R7: When a pin's bit at offset 0x34 is 0, the pin uses edge detection. A polarity bit of 0 selects rising edges and a polarity bit of 1 selects falling edges. Each edge is found by comparing the synchronized sample with the previous sample.
- R8: In edge mode, a pin whose bit at offset 0x38 is 1 records both rising and falling edges, whatever its polarity bit holds.
- R9: A status bit is raised only for a pin whose bit at offset 0x20 is 1.
- R10: The status register (offset 0x24) is sticky. A write to offset 0x30 clears the status bits where the written word holds ones. If a new event and a clear hit the same bit in the same cycle, the new event wins.
- R11: `irq_o` is high exactly when some status bit is set and its mask bit (offset 0x2C) is 0. Masking does not change the status register.
- R12: The pull-enable (0x18), pull-type (0x1C), debounce-enable (0x40) and debounce-prescale (0x44) registers read back what was written and have no effect on `pin_o`, `pin_oe_o` or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | 32 | Pad input levels |
| pin_o | output | 32 | Pad output data |
| pin_oe_o | output | 32 | Pad output enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
A software clear of the status register can land on the same clock edge as a new detected event. That event may be on the pin being cleared or on another pin.

The bench times an input transition so that the synchronized edge reaches the detector on exactly the edge that captures a clear write covering two pins. One pin is already pending and the other is just being detected. The bench then expects the old event to be gone and the new event to remain.

Randomized trials also clear all status while level-mode pins are still active. They judge re-assertion by comparing against a bench model of the final status.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [7:0] OFF_DOUT     = 8'h00;
  localparam logic [7:0] OFF_DIN      = 8'h04;
  localparam logic [7:0] OFF_DIR      = 8'h08;
  localparam logic [7:0] OFF_SET      = 8'h10;
  localparam logic [7:0] OFF_CLR      = 8'h14;
  localparam logic [7:0] OFF_PULL_EN  = 8'h18;
  localparam logic [7:0] OFF_PULL_SEL = 8'h1C;
  localparam logic [7:0] OFF_IRQ_EN   = 8'h20;
  localparam logic [7:0] OFF_IRQ_STAT = 8'h24;
  localparam logic [7:0] OFF_IRQ_MASK = 8'h2C;
  localparam logic [7:0] OFF_IRQ_CLR  = 8'h30;
  localparam logic [7:0] OFF_TRIG_LVL = 8'h34;
  localparam logic [7:0] OFF_TRIG_ANY = 8'h38;
  localparam logic [7:0] OFF_TRIG_NEG = 8'h3C;
  localparam logic [7:0] OFF_DB_EN    = 8'h40;
  localparam logic [7:0] OFF_DB_DIV   = 8'h44;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sample_i,
  input  logic [WIDTH-1:0] lvl_mode_i,
  input  logic [WIDTH-1:0] neg_i,
  input  logic [WIDTH-1:0] any_edge_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] prev_q, status_q, det;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise     = sample_i[g] & ~prev_q[g];
    assign fall     = ~sample_i[g] & prev_q[g];
    assign lvl_hit  = sample_i[g] ^ neg_i[g];
    assign edge_hit = any_edge_i[g] ? (rise | fall) : (neg_i[g] ? fall : rise);
    assign det[g]   = en_i[g] & (lvl_mode_i[g] ? lvl_hit : edge_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sample_i;
      status_q <= (status_q & ~clr_i) | det;  // new event beats clear
    end
  end

  assign status_o = status_q;

  // R9
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(en_i)) == '0));

  // R10
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((status_q & $past(clr_i) & ~$past(det)) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             irq_o
);
  logic [NPINS-1:0] dout_q, dir_q, pull_en_q, pull_sel_q;
  logic [NPINS-1:0] irq_en_q, irq_mask_q, trig_lvl_q, trig_any_q, trig_neg_q;
  logic [NPINS-1:0] db_en_q, db_div_q;
  logic [NPINS-1:0] sample, status, clr_vec;

  gpio_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sample)
  );

  assign clr_vec = (wr_en_i && addr_i == OFF_IRQ_CLR) ? wdata_i : '0;

  gpio_irq_detect #(.WIDTH(NPINS)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample),
    .lvl_mode_i(trig_lvl_q),
    .neg_i     (trig_neg_q),
    .any_edge_i(trig_any_q),
    .en_i      (irq_en_q),
    .clr_i     (clr_vec),
    .status_o  (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q     <= '0;
      dir_q      <= '0;
      pull_en_q  <= '0;
      pull_sel_q <= '0;
      irq_en_q   <= '0;
      irq_mask_q <= '0;
      trig_lvl_q <= '0;
      trig_any_q <= '0;
      trig_neg_q <= '0;
      db_en_q    <= '0;
      db_div_q   <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFF_DOUT:     dout_q     <= wdata_i;
        OFF_SET:      dout_q     <= dout_q | wdata_i;
        OFF_CLR:      dout_q     <= dout_q & ~wdata_i;
        OFF_DIR:      dir_q      <= wdata_i;
        OFF_PULL_EN:  pull_en_q  <= wdata_i;
        OFF_PULL_SEL: pull_sel_q <= wdata_i;
        OFF_IRQ_EN:   irq_en_q   <= wdata_i;
        OFF_IRQ_MASK: irq_mask_q <= wdata_i;
        OFF_TRIG_LVL: trig_lvl_q <= wdata_i;
        OFF_TRIG_ANY: trig_any_q <= wdata_i;
        OFF_TRIG_NEG: trig_neg_q <= wdata_i;
        OFF_DB_EN:    db_en_q    <= wdata_i;
        OFF_DB_DIV:   db_div_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_DOUT:     rdata_o = dout_q;
      OFF_DIN:      rdata_o = sample;
      OFF_DIR:      rdata_o = dir_q;
      OFF_PULL_EN:  rdata_o = pull_en_q;
      OFF_PULL_SEL: rdata_o = pull_sel_q;
      OFF_IRQ_EN:   rdata_o = irq_en_q;
      OFF_IRQ_STAT: rdata_o = status;
      OFF_IRQ_MASK: rdata_o = irq_mask_q;
      OFF_TRIG_LVL: rdata_o = trig_lvl_q;
      OFF_TRIG_ANY: rdata_o = trig_any_q;
      OFF_TRIG_NEG: rdata_o = trig_neg_q;
      OFF_DB_EN:    rdata_o = db_en_q;
      OFF_DB_DIV:   rdata_o = db_div_q;
      default:      rdata_o = '0;
    endcase
  end

  assign pin_o    = dout_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(status & ~irq_mask_q);

  // R3
  set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_SET) |=> ((pin_o & $past(wdata_i)) == $past(wdata_i)));

  // R4
  clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_CLR) |=> ((pin_o & $past(wdata_i)) == '0));
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_port dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_status(input logic [31:0] a, b, lvl, neg, any, en);
    logic [31:0] r = '0;
    for (int p = 0; p < 32; p++) begin
      logic act_a, act_b, rise, fall;
      act_a = a[p] ^ neg[p];
      act_b = b[p] ^ neg[p];
      rise  = ~a[p] & b[p];
      fall  = a[p] & ~b[p];
      if (lvl[p]) r[p] = act_a | act_b;
      else if (any[p]) r[p] = rise | fall;
      else r[p] = neg[p] ? fall : rise;
      r[p] = r[p] & en[p];
    end
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, model;
    void'($urandom(32'h5eed_0017));
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    chk("R1 pin_o", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq", {31'b0, irq}, '0);
    rd(8'h24, v); chk("R1 status", v, '0);
    rd(8'h20, v); chk("R1 enable", v, '0);

    // R2 direct output and direction
    wr(8'h00, 32'hA5A5_0F0F); chk("R2 pin_o", pin_out, 32'hA5A5_0F0F);
    rd(8'h00, v); chk("R2 dout readback", v, 32'hA5A5_0F0F);
    wr(8'h08, 32'hFFFF_0000); chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(8'h08, v); chk("R2 dir readback", v, 32'hFFFF_0000);

    // R3 / R4 aliases, random
    model = 32'hA5A5_0F0F;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      int op;
      d = $urandom; op = $urandom_range(0, 2);
      if (op == 0) begin wr(8'h00, d); model = d; end
      else if (op == 1) begin wr(8'h10, d); model = model | d; end
      else begin wr(8'h14, d); model = model & ~d; end
      chk(op == 1 ? "R3 set alias" : (op == 2 ? "R4 clear alias" : "R2 direct"), pin_out, model);
    end
    wr(8'h10, 32'hFFFF_FFFF); chk("R3 set all", pin_out, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_0001); chk("R4 clear bit0", pin_out, 32'hFFFF_FFFE);

    // R5 two-flop input timing
    @(negedge clk); addr = 8'h04; pin_in = 32'h1234_5678;
    @(posedge clk); #1; chk("R5 one edge old", rdata, '0);
    @(posedge clk); #1; chk("R5 two edges new", rdata, 32'h1234_5678);
    pin_in = '0; settle(4);

    // R12 storage-only registers
    wr(8'h00, 32'h0000_00FF);
    wr(8'h18, 32'hDEAD_BEEF); wr(8'h1C, 32'h1357_9BDF);
    wr(8'h40, 32'hCAFE_F00D); wr(8'h44, 32'h0000_1234);
    rd(8'h18, v); chk("R12 pull en", v, 32'hDEAD_BEEF);
    rd(8'h1C, v); chk("R12 pull sel", v, 32'h1357_9BDF);
    rd(8'h40, v); chk("R12 db en", v, 32'hCAFE_F00D);
    rd(8'h44, v); chk("R12 db div", v, 32'h0000_1234);
    chk("R12 pin_o unaffected", pin_out, 32'h0000_00FF);
    chk("R12 pin_oe unaffected", pin_oe, 32'hFFFF_0000);
    chk("R12 irq unaffected", {31'b0, irq}, '0);

    // R6 level low, re-assert after clear
    wr(8'h34, 32'h0000_0001); wr(8'h3C, 32'h0000_0001); wr(8'h20, 32'h0000_0001);
    settle(2);
    rd(8'h24, v); chk("R6 active-low level", v, 32'h1);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R6 re-assert after clear", v, 32'h1);
    pin_in[0] = 1'b1; settle(4);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R6 inactive cleared", v, 32'h0);

    // R9 disabled pin ignored
    wr(8'h20, 32'h0); wr(8'h34, 32'h0); wr(8'h3C, 32'h0); wr(8'h38, 32'h0);
    pin_in = 32'hFFFF_FFFF; settle(4);
    rd(8'h24, v); chk("R9 disabled no status", v, 32'h0);
    chk("R9 irq low", {31'b0, irq}, '0);
    pin_in = '0; settle(4);

    // R10 clear and new event on the same edge
    wr(8'h20, 32'h3);
    pin_in[1] = 1'b1; settle(4);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 8'h30; wdata = 32'h3;
    @(negedge clk); wr_en = 1'b0;
    rd(8'h24, v); chk("R10 new event beats clear", v, 32'h1);
    wr(8'h30, 32'h1);
    rd(8'h24, v); chk("R10 sticky cleared", v, 32'h0);
    pin_in = '0; settle(4); wr(8'h30, 32'hFFFF_FFFF);

    // R11 masking
    wr(8'h20, 32'h4); pin_in[2] = 1'b1; settle(4);
    chk("R11 irq unmasked", {31'b0, irq}, 32'h1);
    wr(8'h2C, 32'h4);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h24, v); chk("R11 status kept under mask", v, 32'h4);
    pin_in = '0; wr(8'h2C, 32'h0); settle(4); wr(8'h30, 32'hFFFF_FFFF);

    // R6 R7 R8 random trigger trials
    for (int t = 0; t < 60; t++) begin
      logic [31:0] a, b, lvl, neg, any, en, msk, e;
      a = $urandom; b = $urandom; lvl = $urandom; neg = $urandom;
      any = $urandom; en = $urandom; msk = $urandom;
      if (t < 4) begin lvl = '0; any = (t == 3) ? '1 : '0; neg = (t == 2) ? '1 : '0; end
      wr(8'h34, lvl); wr(8'h3C, neg); wr(8'h38, any); wr(8'h20, en); wr(8'h2C, msk);
      pin_in = a; settle(5);
      wr(8'h30, 32'hFFFF_FFFF);
      pin_in = b; settle(5);
      e = exp_status(a, b, lvl, neg, any, en);
      rd(8'h24, v);
      chk(t < 4 ? "R7 edge polarity" : "R6 R7 R8 trigger", v, e);
      chk("R11 irq combine", {31'b0, irq}, {31'b0, |(e & ~msk)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule